// File: doc/BRIEF.md
# Fractional Medium-Rate Infrared Bit-Timing Generator

This block sets the bit timing for the medium-rate infrared link. It runs from a 48 MHz clock and supports 1.152 Mbit/s and 0.576 Mbit/s. 48 MHz does not divide evenly into 1.152 MHz, so the bit periods rotate through three lengths: a long period (42 clocks), a short period (41 clocks) and another long period (42 clocks). Averaged over the rotation, the rate error stays inside the link's tolerance. At the slower rate every length is doubled.

On the transmit side, the framing logic starts a frame with a one-cycle `tx_go` and ends it with `tx_stop`. In every cycle where the block raises `tx_load`, the framing logic presents the next line bit on `tx_bit`. For each 1 bit, the block drives an optical pulse on `tx_pulse` at the start of that bit period, about a quarter of the period long.

On the receive side, the receiver is armed by holding `rx_arm` high. The first rising edge on the line then starts a second copy of the same rotation, and the block raises `rx_sample` near the middle of each received bit. The block suppresses receive sampling and receive starts while a transmit frame is in progress.

Top module: `mir_bit_timer`

## Requirements
- R1: During and immediately after reset, every output is low and both directions are idle.
- R2: At 1.152 Mbit/s the transmit bit periods repeat the lengths 42, 41, 42 clocks, starting with the first 42. `tx_load` is high in the `tx_go` cycle and in the last cycle of every running period. `tx_bit` is captured in each `tx_load` cycle.
- R3: If `half_rate` is 1 in the `tx_go` cycle, the periods are 84, 82, 84 clocks. The rate captured at `tx_go` holds for the whole frame, even if `half_rate` changes later.
- R4: A `tx_go` that arrives while a frame is running restarts the rotation at its first 42-clock entry. `tx_go` wins over `tx_stop` in the same cycle.
- R5: `tx_stop` makes `tx_busy` low in the next cycle. No `tx_load` is raised in the stop cycle.
- R6: A captured 1 bit makes `tx_pulse` high for the first 10 clocks of its period, or the first 20 clocks at half rate. A captured 0 bit gives no pulse. `tx_pulse` is never high while transmit is idle.
- R7: A receive cadence starts when `rx_in` rises (low in the previous cycle, high now) while all of the following hold: `rx_arm` is high, receive is idle and transmit is idle. The rate is taken from `half_rate` in that cycle. Period 0 (42 or 84 clocks) begins in the next cycle.
- R8: While receiving, `rx_sample` is high once per period, at offset L-1-floor(L/2) counted from 0 at the period start, where L is the period length. The receive periods follow the same rotation as R2 and R3.
- R9: `rx_sample` stays low while `tx_busy` is high. Rising edges on `rx_in` while receive is already running do not restart it.
- R10: `rx_stop` makes `rx_busy` low in the next cycle, unless a receive start occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | 1 selects 0.576 Mbit/s; captured at each frame start |
| tx_go | input | 1 | One-cycle transmit frame start; restarts the rotation |
| tx_stop | input | 1 | Ends the transmit cadence |
| tx_bit | input | 1 | Next line bit, captured while tx_load is high |
| tx_load | output | 1 | Request for the next bit |
| tx_pulse | output | 1 | Optical transmit pulse |
| tx_busy | output | 1 | Transmit cadence running |
| rx_arm | input | 1 | Lets a line edge start receive timing |
| rx_in | input | 1 | Received line, high when light is detected |
| rx_stop | input | 1 | Ends the receive cadence |
| rx_sample | output | 1 | Mid-bit receive sample strobe |
| rx_busy | output | 1 | Receive cadence running |

## Verification
The hardest behaviour to reach is the boundary between periods. A period wrap, the phase step from the short entry back to a long one, a restart and a stop can all land on the same clock, and each combination has a different outcome. Directed cases place `tx_stop` and a second `tx_go` exactly on a wrap cycle, and put a `tx_go` and a `tx_stop` in the same cycle. Long random frames mix both rates, random bits and stray line edges during transmit and receive. A cycle-by-cycle reference model in the bench counts periods from R2, R3 and R8 and compares every output in every cycle.

// File: rtl/mir_timing_pkg.sv
package mir_timing_pkg;
    localparam int LONG_CLKS  = 42;
    localparam int SHORT_CLKS = 41;
    localparam int NUM_PHASES = 3;
    localparam int PULSE_CLKS = 10;
    localparam int CNT_W      = $clog2(2 * LONG_CLKS + 1);
    localparam int PH_W       = $clog2(NUM_PHASES);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PH_W-1:0]  ph_t;

    typedef struct packed {
        logic run;
        logic half;
        ph_t  ph;
        cnt_t cnt;
    } cad_t;

    // middle entry of the rotation is the short one
    function automatic cnt_t period_len(input ph_t ph, input logic half);
        int n;
        n = (ph == ph_t'(1)) ? SHORT_CLKS : LONG_CLKS;
        if (half) n = 2 * n;
        return cnt_t'(n);
    endfunction

    function automatic ph_t next_phase(input ph_t ph);
        return (ph == ph_t'(NUM_PHASES - 1)) ? '0 : ph + ph_t'(1);
    endfunction

    function automatic cnt_t pulse_len(input logic half);
        return half ? cnt_t'(2 * PULSE_CLKS) : cnt_t'(PULSE_CLKS);
    endfunction
endpackage

// File: rtl/mir_cadence.sv
module mir_cadence
    import mir_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic half_in,
    output logic running,
    output logic half_o,
    output cnt_t cnt_o,
    output cnt_t len_o,
    output logic wrap_o
);
    cad_t st_d, st_q;
    cnt_t len_cur;
    ph_t  ph_nxt;

    always_comb begin
        len_cur = period_len(st_q.ph, st_q.half);
        ph_nxt  = next_phase(st_q.ph);
        st_d    = st_q;
        if (start) begin
            st_d.run  = 1'b1;
            st_d.half = half_in;
            st_d.ph   = '0;
            st_d.cnt  = period_len('0, half_in) - cnt_t'(1);
        end else if (stop) begin
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.ph  = ph_nxt;
                st_d.cnt = period_len(ph_nxt, st_q.half) - cnt_t'(1);
            end else begin
                st_d.cnt = st_q.cnt - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign half_o  = st_q.half;
    assign cnt_o   = st_q.cnt;
    assign len_o   = len_cur;
    assign wrap_o  = st_q.run && (st_q.cnt == '0);

    // R2
    short_after_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !start && !stop && st_q.ph == '0) |=>
        (st_q.run && st_q.ph == ph_t'(1) &&
         st_q.cnt == (st_q.half ? cnt_t'(2*SHORT_CLKS-1) : cnt_t'(SHORT_CLKS-1))));
    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.run && st_q.ph == '0));
    // R5
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !st_q.run);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < len_cur && st_q.ph != ph_t'(3)));
endmodule

// File: rtl/mir_tx_shaper.sv
module mir_tx_shaper
    import mir_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic stop,
    input  logic bit_in,
    input  logic run,
    input  logic half,
    input  logic wrap,
    input  cnt_t cnt,
    input  cnt_t len,
    output logic load,
    output logic pulse
);
    logic bit_d, bit_q;

    always_comb begin
        load  = go || (wrap && !stop);
        bit_d = load ? bit_in : bit_q;
        pulse = run && bit_q && (cnt >= (len - pulse_len(half)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    // R6
    pulse_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> run);
    // R6
    pulse_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bit_in) |=> pulse);
    // R6
    no_pulse_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bit_in) |=> !pulse);
endmodule

// File: rtl/mir_rx_trigger.sv
module mir_rx_trigger
    import mir_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line,
    input  logic rx_run,
    input  logic tx_run,
    input  cnt_t cnt,
    input  cnt_t len,
    output logic start,
    output logic sample
);
    logic line_d, line_q;

    always_comb begin
        line_d = line;
        start  = arm && line && !line_q && !rx_run && !tx_run;
        sample = rx_run && !tx_run && (cnt == (len >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end

    // R7
    first_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rx_run && cnt == len - cnt_t'(1)));
endmodule

// File: rtl/mir_bit_timer.sv
module mir_bit_timer
    import mir_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    input  logic tx_go,
    input  logic tx_stop,
    input  logic tx_bit,
    output logic tx_load,
    output logic tx_pulse,
    output logic tx_busy,
    input  logic rx_arm,
    input  logic rx_in,
    input  logic rx_stop,
    output logic rx_sample,
    output logic rx_busy
);
    logic tx_half, tx_wrap, rx_half, rx_wrap, rx_go;
    cnt_t tx_cnt, tx_len, rx_cnt, rx_len;

    mir_cadence u_tx_cad (
        .clk(clk), .rst_n(rst_n), .start(tx_go), .stop(tx_stop),
        .half_in(half_rate), .running(tx_busy), .half_o(tx_half),
        .cnt_o(tx_cnt), .len_o(tx_len), .wrap_o(tx_wrap)
    );

    mir_tx_shaper u_shaper (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .stop(tx_stop),
        .bit_in(tx_bit), .run(tx_busy), .half(tx_half), .wrap(tx_wrap),
        .cnt(tx_cnt), .len(tx_len), .load(tx_load), .pulse(tx_pulse)
    );

    mir_cadence u_rx_cad (
        .clk(clk), .rst_n(rst_n), .start(rx_go), .stop(rx_stop),
        .half_in(half_rate), .running(rx_busy), .half_o(rx_half),
        .cnt_o(rx_cnt), .len_o(rx_len), .wrap_o(rx_wrap)
    );

    mir_rx_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .line(rx_in),
        .rx_run(rx_busy), .tx_run(tx_busy), .cnt(rx_cnt), .len(rx_len),
        .start(rx_go), .sample(rx_sample)
    );

    // R9
    rx_quiet_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_sample);
    // R9
    no_rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && !rx_stop && !rx_wrap) |=> (rx_busy && rx_half == $past(rx_half)));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_busy |-> !rx_sample);
endmodule

// File: tb/tb_mir_bit_timer.sv
module tb_mir_bit_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_rate = 0, tx_go = 0, tx_stop = 0, tx_bit = 0;
    logic rx_arm = 0, rx_in = 0, rx_stop = 0;
    logic tx_load, tx_pulse, tx_busy, rx_sample, rx_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic m_trun = 0, m_thalf = 0, m_tbit = 0;
    int   m_tph = 0, m_toff = 0;
    logic m_rrun = 0, m_rhalf = 0, m_rinq = 0;
    int   m_rph = 0, m_roff = 0;

    always #4 clk = ~clk;

    mir_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .tx_go(tx_go),
        .tx_stop(tx_stop), .tx_bit(tx_bit), .tx_load(tx_load),
        .tx_pulse(tx_pulse), .tx_busy(tx_busy), .rx_arm(rx_arm),
        .rx_in(rx_in), .rx_stop(rx_stop), .rx_sample(rx_sample),
        .rx_busy(rx_busy)
    );

    function automatic int mlen(int ph, logic half);
        int n;
        n = (ph == 1) ? 41 : 42;
        return half ? 2 * n : n;
    endfunction

    task automatic cmp(string req, string name, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b exp %0b at cycle %0d", req, name, got, exp, cycles);
        end
    endtask

    task automatic check_outputs();
        logic e_load, e_pulse, e_samp;
        int tl, rl;
        tl = mlen(m_tph, m_thalf);
        rl = mlen(m_rph, m_rhalf);
        e_load  = tx_go || (m_trun && !tx_stop && m_toff == tl - 1);
        e_pulse = m_trun && m_tbit && (m_toff < (m_thalf ? 20 : 10));
        e_samp  = m_rrun && !m_trun && (m_roff == rl - 1 - rl / 2);
        cmp(cur_req, "tx_load (R2)", tx_load, e_load);
        cmp(cur_req, "tx_pulse (R6)", tx_pulse, e_pulse);
        cmp(cur_req, "tx_busy (R5)", tx_busy, m_trun);
        cmp(cur_req, "rx_sample (R8)", rx_sample, e_samp);
        cmp(cur_req, "rx_busy (R10)", rx_busy, m_rrun);
    endtask

    task automatic model_step();
        logic rstart;
        int l;
        rstart = rx_arm && rx_in && !m_rinq && !m_rrun && !m_trun;
        if (rstart) begin
            m_rrun = 1; m_rhalf = half_rate; m_rph = 0; m_roff = 0;
        end else if (rx_stop) begin
            m_rrun = 0;
        end else if (m_rrun) begin
            l = mlen(m_rph, m_rhalf);
            if (m_roff == l - 1) begin m_roff = 0; m_rph = (m_rph == 2) ? 0 : m_rph + 1; end
            else m_roff++;
        end
        m_rinq = rx_in;
        if (tx_go) begin
            m_trun = 1; m_tph = 0; m_toff = 0; m_thalf = half_rate; m_tbit = tx_bit;
        end else if (tx_stop) begin
            m_trun = 0;
        end else if (m_trun) begin
            l = mlen(m_tph, m_thalf);
            if (m_toff == l - 1) begin
                m_toff = 0; m_tph = (m_tph == 2) ? 0 : m_tph + 1; m_tbit = tx_bit;
            end else m_toff++;
        end
    endtask

    // called at negedge with inputs already set
    task automatic cycle();
        #1;
        check_outputs();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse_go(logic half, logic b);
        half_rate = half; tx_bit = b; tx_go = 1;
        cycle();
        tx_go = 0;
    endtask

    task automatic tx_stop_now();
        tx_stop = 1; cycle(); tx_stop = 0;
    endtask

    task automatic rx_edge();
        rx_in = 1; cycle(); rx_in = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7321);
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) begin
            #1; check_outputs(); @(negedge clk);
        end
        rst_n = 1;
        idle(3);

        // R2 full rate, all ones
        cur_req = "R2";
        pulse_go(0, 1);
        idle(42 + 41 + 42 + 42 + 10);
        // R6 alternating bits
        cur_req = "R6";
        for (int i = 0; i < 300; i++) begin tx_bit = i[6]; cycle(); end
        tx_stop_now();
        idle(4);

        // R3 half rate, rate input toggled mid frame
        cur_req = "R3";
        pulse_go(1, 1);
        half_rate = 0;
        idle(84 + 82 + 84 + 30);
        tx_stop_now();
        idle(3);

        // R4 restart mid-frame on a wrap cycle, and go+stop together
        cur_req = "R4";
        pulse_go(0, 1);
        idle(42 + 40);
        tx_go = 1; tx_bit = 1; cycle(); tx_go = 0;
        idle(60);
        tx_go = 1; tx_stop = 1; cycle(); tx_go = 0; tx_stop = 0;
        idle(50);

        // R5 stop landing on the last cycle of a period
        cur_req = "R5";
        pulse_go(0, 0);
        idle(41);
        tx_stop_now();
        idle(5);

        // R7 / R8 receive cadence at both rates
        cur_req = "R7";
        rx_arm = 1; half_rate = 0;
        idle(2);
        rx_edge();
        cur_req = "R8";
        idle(42 * 4);
        cur_req = "R10";
        rx_stop = 1; cycle(); rx_stop = 0;
        idle(3);
        cur_req = "R8";
        half_rate = 1; rx_edge(); half_rate = 0;
        idle(84 * 4);
        rx_stop = 1; cycle(); rx_stop = 0;

        // R9 edges while running, tx overlapping rx
        cur_req = "R9";
        rx_edge();
        idle(20);
        for (int i = 0; i < 6; i++) begin rx_edge(); idle(13); end
        pulse_go(0, 1);
        idle(120);
        rx_edge();
        idle(10);
        tx_stop_now();
        idle(100);
        cur_req = "R10";
        rx_stop = 1; cycle(); rx_stop = 0;
        idle(4);
        // edge ignored while disarmed
        cur_req = "R7";
        rx_arm = 0; rx_edge(); idle(10); rx_arm = 1;

        // constrained random frames
        for (int f = 0; f < 30; f++) begin
            int nbits, len;
            cur_req = (f % 2) ? "R3" : "R2";
            nbits = 3 + int'($urandom % 10);
            pulse_go(1'($urandom % 2), 1'($urandom % 2));
            len = 0;
            while (len < nbits * 84) begin
                tx_bit  = 1'($urandom % 2);
                rx_in   = ($urandom % 23 == 0);
                rx_arm  = 1'($urandom % 2);
                half_rate = 1'($urandom % 2);
                if ($urandom % 700 == 0) tx_go = 1;
                cycle();
                tx_go = 0;
                len++;
            end
            rx_in = 0;
            tx_stop_now();
            cur_req = "R8";
            rx_arm = 1;
            half_rate = 1'($urandom % 2);
            rx_edge();
            for (int i = 0; i < 200 + int'($urandom % 300); i++) begin
                rx_in = ($urandom % 31 == 0);
                cycle();
            end
            rx_in = 0;
            rx_stop = 1; cycle(); rx_stop = 0;
            idle(2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule